// File: doc/BRIEF.md
# Trap Return Status Update Unit

This unit carries out the two trap-return operations of a core that has machine (M), supervisor (S) and user (U) privilege levels. One is the machine-level return and the other is the supervisor-level return. The pipeline raises a request for one cycle. With that request it presents the return kind, the current privilege and virtualization state, the interrupt-enable stack fields of the status register, the two saved exception PCs, and two configuration bits. The first configuration bit says whether compressed instructions are supported. The second says whether the hypervisor extension is present.

In that one request cycle the unit decides whether the return is allowed. If it is allowed, the unit pops the matching interrupt-enable stack, selects the new privilege and virtualization flag, and picks the return PC. All results are written into output registers on the next clock edge, and a done pulse marks them. A return that is refused leaves every status output at the value that was presented, and instead raises an exception flag with a cause code.

Top module: `trap_return_unit`

## Requirements
- R1: A cycle with `i_req`=1 makes `o_done`=1 for exactly the following cycle, and all outputs update on that same edge. When `i_req`=0, `o_done` is 0 in the next cycle and every other output keeps its value.
- R2: `i_is_mret`=1 selects the machine return and 0 selects the supervisor return. Privilege encoding is U=2'b00, S=2'b01, M=2'b11. A machine return with a privilege other than 2'b11 raises `o_exc` with `o_cause`=2 (illegal instruction).
- R3: A supervisor return with a privilege numerically below S (2'b00) raises `o_exc` with `o_cause`=2.
- R4: A supervisor return from a privilege other than M while `i_tsr`=1 raises `o_exc` with `o_cause`=2. `i_tsr` has no effect on a machine return.
- R5: When `i_rvc`=0 and bits [1:0] of the selected return PC are nonzero, the return raises `o_exc` with `o_cause`=0 (misaligned fetch address). This check comes after the privilege check of R2/R3 and takes precedence over the trap bit of R4. When `i_rvc`=1, bits [1:0] never raise an exception.
- R6: On an excepting return, `o_priv`, `o_virt` and all status outputs equal the values presented with the request. On a successful return, `o_exc`=0 and `o_cause`=0.
- R7: A successful machine return gives `o_priv`=`i_mpp`, `o_mie`=`i_mpie`, `o_mpie`=1, `o_mpp`=2'b00 and `o_mpv`=0. The supervisor fields pass through unchanged.
- R8: A successful machine return sets `o_virt`=`i_mpv` when `i_hyp`=1 and keeps `o_virt`=`i_virt` when `i_hyp`=0.
- R9: A successful supervisor return gives `o_priv`=S when `i_spp`=1 and U when `i_spp`=0, together with `o_sie`=`i_spie`, `o_spie`=1 and `o_spp`=0. The machine fields pass through unchanged.
- R10: A successful supervisor return with `i_hyp`=1 and `i_virt`=0 sets `o_virt`=`i_spv` and `o_spv`=0. In every other case it leaves virtualization and `o_spv` unchanged.
- R11: `o_pc` is `i_mepc` after a machine return and `i_sepc` after a supervisor return.
- R12: After reset, `o_done`=0, `o_exc`=0 and `o_priv`=2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| i_req | input | 1 | One-cycle return request |
| i_is_mret | input | 1 | 1 = machine return, 0 = supervisor return |
| i_priv | input | 2 | Current privilege |
| i_virt | input | 1 | Current virtualization flag |
| i_mie | input | 1 | Machine interrupt enable |
| i_mpie | input | 1 | Machine prior interrupt enable |
| i_mpp | input | 2 | Machine prior privilege |
| i_mpv | input | 1 | Machine prior virtualization |
| i_sie | input | 1 | Supervisor interrupt enable |
| i_spie | input | 1 | Supervisor prior interrupt enable |
| i_spp | input | 1 | Supervisor prior privilege |
| i_spv | input | 1 | Hypervisor prior virtualization bit |
| i_tsr | input | 1 | Trap supervisor-return control bit |
| i_mepc | input | XLEN | Machine saved exception PC |
| i_sepc | input | XLEN | Supervisor saved exception PC |
| i_rvc | input | 1 | Compressed instructions supported |
| i_hyp | input | 1 | Hypervisor extension present |
| o_done | output | 1 | Result valid pulse |
| o_exc | output | 1 | Return was refused |
| o_cause | output | CAUSE_W | Exception cause code |
| o_pc | output | XLEN | Return PC |
| o_priv | output | 2 | New privilege |
| o_virt | output | 1 | New virtualization flag |
| o_mie | output | 1 | Updated machine interrupt enable |
| o_mpie | output | 1 | Updated machine prior interrupt enable |
| o_mpp | output | 2 | Updated machine prior privilege |
| o_mpv | output | 1 | Updated machine prior virtualization |
| o_sie | output | 1 | Updated supervisor interrupt enable |
| o_spie | output | 1 | Updated supervisor prior interrupt enable |
| o_spp | output | 1 | Updated supervisor prior privilege |
| o_spv | output | 1 | Updated hypervisor prior virtualization bit |

## Verification
The hardest case to reach is a supervisor return from S privilege that meets both the trap control bit and a misaligned return PC with compressed support off. Here the misaligned cause must win over the illegal one. Another hard case is a supervisor return that restores virtualization only when the hypervisor bit is set and virtualization is currently off. The stimulus reaches these cases by sweeping every combination of return kind, all four privilege codes, trap bit, compressed support, hypervisor presence, current virtualization and the four low PC bit patterns. For each combination it applies several status-field patterns, so every priority pairing and every restore condition occurs with both values of the popped bits.

// File: rtl/trp_pkg.sv
package trp_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;

  // interrupt-enable stack and related status fields
  typedef struct packed {
    logic       mie;
    logic       mpie;
    logic [1:0] mpp;
    logic       mpv;
    logic       sie;
    logic       spie;
    logic       spp;
    logic       spv;
  } stack_t;

  localparam int unsigned CAUSE_ILLEGAL  = 2;
  localparam int unsigned CAUSE_MISALIGN = 0;

endpackage

// File: rtl/trp_gate.sv
// Decides whether a return may complete and selects its target PC.
module trp_gate
  import trp_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 4
) (
  input  logic               is_mret,
  input  logic [1:0]         priv,
  input  logic               tsr,
  input  logic               rvc,
  input  logic [XLEN-1:0]    mepc,
  input  logic [XLEN-1:0]    sepc,
  output logic               exc,
  output logic [CAUSE_W-1:0] cause,
  output logic [XLEN-1:0]    pc
);

  localparam logic [CAUSE_W-1:0] C_ILL = CAUSE_W'(CAUSE_ILLEGAL);
  localparam logic [CAUSE_W-1:0] C_MIS = CAUSE_W'(CAUSE_MISALIGN);

  logic at_m;
  logic at_least_s;
  logic low_bits_bad;
  logic priv_fail;
  logic trap_fail;

  always_comb begin
    at_m         = (priv == PRIV_M);
    at_least_s   = (priv >= PRIV_S);
    pc           = is_mret ? mepc : sepc;
    low_bits_bad = !rvc && (pc[1:0] != 2'b00);
    priv_fail    = is_mret ? !at_m : !at_least_s;
    // the trap control bit only applies to the supervisor return
    trap_fail    = !is_mret && tsr && !at_m;
  end

  // priority: privilege, then alignment, then trap control bit
  always_comb begin
    exc   = 1'b0;
    cause = '0;
    if (priv_fail) begin
      exc   = 1'b1;
      cause = C_ILL;
    end else if (low_bits_bad) begin
      exc   = 1'b1;
      cause = C_MIS;
    end else if (trap_fail) begin
      exc   = 1'b1;
      cause = C_ILL;
    end
  end

endmodule

// File: rtl/trp_pop.sv
// Computes the popped interrupt-enable stack, privilege and virtualization.
module trp_pop
  import trp_pkg::*;
(
  input  logic       is_mret,
  input  logic       hyp,
  input  logic       virt,
  input  stack_t     cur,
  output stack_t     nxt,
  output logic [1:0] nxt_priv,
  output logic       nxt_virt
);

  stack_t m_st;
  stack_t s_st;
  logic   m_virt;
  logic   s_virt;
  logic   s_restore;

  // machine return
  always_comb begin
    m_st      = cur;
    m_st.mie  = cur.mpie;
    m_st.mpie = 1'b1;
    m_st.mpp  = PRIV_U;
    m_st.mpv  = 1'b0;
    m_virt    = hyp ? cur.mpv : virt;
  end

  // supervisor return
  always_comb begin
    s_restore = hyp && !virt;
    s_st      = cur;
    s_st.sie  = cur.spie;
    s_st.spie = 1'b1;
    s_st.spp  = 1'b0;
    s_st.spv  = s_restore ? 1'b0 : cur.spv;
    s_virt    = s_restore ? cur.spv : virt;
  end

  always_comb begin
    if (is_mret) begin
      nxt      = m_st;
      nxt_priv = cur.mpp;
      nxt_virt = m_virt;
    end else begin
      nxt      = s_st;
      nxt_priv = cur.spp ? PRIV_S : PRIV_U;
      nxt_virt = s_virt;
    end
  end

endmodule

// File: rtl/trp_commit.sv
// Output registers: load on a request, hold otherwise.
module trp_commit
  import trp_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               gate_exc,
  input  logic [CAUSE_W-1:0] gate_cause,
  input  logic [XLEN-1:0]    gate_pc,
  input  stack_t             cur_st,
  input  logic [1:0]         cur_priv,
  input  logic               cur_virt,
  input  stack_t             pop_st,
  input  logic [1:0]         pop_priv,
  input  logic               pop_virt,
  output logic               done_q,
  output logic               exc_q,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [XLEN-1:0]    pc_q,
  output stack_t             st_q,
  output logic [1:0]         priv_q,
  output logic               virt_q
);

  logic               done_d;
  logic               exc_d;
  logic [CAUSE_W-1:0] cause_d;
  logic [XLEN-1:0]    pc_d;
  stack_t             st_d;
  logic [1:0]         priv_d;
  logic               virt_d;
  logic               load_en;

  assign load_en = req;

  always_comb begin
    done_d  = req;
    exc_d   = gate_exc;
    cause_d = gate_exc ? gate_cause : '0;
    pc_d    = gate_pc;
    if (gate_exc) begin
      st_d   = cur_st;
      priv_d = cur_priv;
      virt_d = cur_virt;
    end else begin
      st_d   = pop_st;
      priv_d = pop_priv;
      virt_d = pop_virt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_q   <= 1'b0;
      cause_q <= '0;
      pc_q    <= '0;
      st_q    <= '0;
      priv_q  <= PRIV_M;
      virt_q  <= 1'b0;
    end else if (load_en) begin
      exc_q   <= exc_d;
      cause_q <= cause_d;
      pc_q    <= pc_d;
      st_q    <= st_d;
      priv_q  <= priv_d;
      virt_q  <= virt_d;
    end
  end

endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
  import trp_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               i_req,
  input  logic               i_is_mret,
  input  logic [1:0]         i_priv,
  input  logic               i_virt,
  input  logic               i_mie,
  input  logic               i_mpie,
  input  logic [1:0]         i_mpp,
  input  logic               i_mpv,
  input  logic               i_sie,
  input  logic               i_spie,
  input  logic               i_spp,
  input  logic               i_spv,
  input  logic               i_tsr,
  input  logic [XLEN-1:0]    i_mepc,
  input  logic [XLEN-1:0]    i_sepc,
  input  logic               i_rvc,
  input  logic               i_hyp,
  output logic               o_done,
  output logic               o_exc,
  output logic [CAUSE_W-1:0] o_cause,
  output logic [XLEN-1:0]    o_pc,
  output logic [1:0]         o_priv,
  output logic               o_virt,
  output logic               o_mie,
  output logic               o_mpie,
  output logic [1:0]         o_mpp,
  output logic               o_mpv,
  output logic               o_sie,
  output logic               o_spie,
  output logic               o_spp,
  output logic               o_spv
);

  stack_t             cur_st;
  stack_t             pop_st;
  stack_t             st_q;
  logic [1:0]         pop_priv;
  logic               pop_virt;
  logic               gate_exc;
  logic [CAUSE_W-1:0] gate_cause;
  logic [XLEN-1:0]    gate_pc;

  always_comb begin
    cur_st.mie  = i_mie;
    cur_st.mpie = i_mpie;
    cur_st.mpp  = i_mpp;
    cur_st.mpv  = i_mpv;
    cur_st.sie  = i_sie;
    cur_st.spie = i_spie;
    cur_st.spp  = i_spp;
    cur_st.spv  = i_spv;
  end

  trp_gate #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_gate (
    .is_mret (i_is_mret),
    .priv    (i_priv),
    .tsr     (i_tsr),
    .rvc     (i_rvc),
    .mepc    (i_mepc),
    .sepc    (i_sepc),
    .exc     (gate_exc),
    .cause   (gate_cause),
    .pc      (gate_pc)
  );

  trp_pop u_pop (
    .is_mret  (i_is_mret),
    .hyp      (i_hyp),
    .virt     (i_virt),
    .cur      (cur_st),
    .nxt      (pop_st),
    .nxt_priv (pop_priv),
    .nxt_virt (pop_virt)
  );

  trp_commit #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_commit (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (i_req),
    .gate_exc   (gate_exc),
    .gate_cause (gate_cause),
    .gate_pc    (gate_pc),
    .cur_st     (cur_st),
    .cur_priv   (i_priv),
    .cur_virt   (i_virt),
    .pop_st     (pop_st),
    .pop_priv   (pop_priv),
    .pop_virt   (pop_virt),
    .done_q     (o_done),
    .exc_q      (o_exc),
    .cause_q    (o_cause),
    .pc_q       (o_pc),
    .st_q       (st_q),
    .priv_q     (o_priv),
    .virt_q     (o_virt)
  );

  assign o_mie  = st_q.mie;
  assign o_mpie = st_q.mpie;
  assign o_mpp  = st_q.mpp;
  assign o_mpv  = st_q.mpv;
  assign o_sie  = st_q.sie;
  assign o_spie = st_q.spie;
  assign o_spp  = st_q.spp;
  assign o_spv  = st_q.spv;

endmodule

// File: rtl/trp_checker.sv
module trp_checker #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               i_req,
  input logic               i_is_mret,
  input logic [1:0]         i_priv,
  input logic               i_virt,
  input logic               i_rvc,
  input logic               o_done,
  input logic               o_exc,
  input logic [CAUSE_W-1:0] o_cause,
  input logic [1:0]         o_priv,
  input logic               o_virt,
  input logic               o_mpie,
  input logic [1:0]         o_mpp,
  input logic               o_mpv,
  input logic               o_spie,
  input logic               o_spp
);

  p_done_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    i_req |=> o_done);

  p_no_stray_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !i_req |=> !o_done);

  p_mret_low_priv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (i_req && i_is_mret && i_priv != 2'b11) |=> (o_exc && o_cause == CAUSE_W'(2)));

  p_sret_user_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (i_req && !i_is_mret && i_priv == 2'b00) |=> (o_exc && o_cause == CAUSE_W'(2)));

  p_rvc_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (i_req && i_rvc) |=> !(o_exc && o_cause == CAUSE_W'(0)));

  p_exc_keeps_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (o_done && o_exc) |-> (o_priv == $past(i_priv) && o_virt == $past(i_virt)));

  p_mret_stack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (o_done && !o_exc && $past(i_is_mret)) |-> (o_mpie && o_mpp == 2'b00 && !o_mpv));

  p_sret_stack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (o_done && !o_exc && !$past(i_is_mret)) |-> (o_spie && !o_spp));

endmodule

bind trap_return_unit trp_checker #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_trp_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .i_req     (i_req),
  .i_is_mret (i_is_mret),
  .i_priv    (i_priv),
  .i_virt    (i_virt),
  .i_rvc     (i_rvc),
  .o_done    (o_done),
  .o_exc     (o_exc),
  .o_cause   (o_cause),
  .o_priv    (o_priv),
  .o_virt    (o_virt),
  .o_mpie    (o_mpie),
  .o_mpp     (o_mpp),
  .o_mpv     (o_mpv),
  .o_spie    (o_spie),
  .o_spp     (o_spp)
);

// File: tb/tb_trap_return_unit.sv
`timescale 1ns/1ps
module tb_trap_return_unit;

  localparam int XLEN    = 32;
  localparam int CAUSE_W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic i_req, i_is_mret, i_virt, i_mie, i_mpie, i_mpv, i_sie, i_spie, i_spp, i_spv;
  logic i_tsr, i_rvc, i_hyp;
  logic [1:0] i_priv, i_mpp;
  logic [XLEN-1:0] i_mepc, i_sepc;
  logic o_done, o_exc, o_virt, o_mie, o_mpie, o_mpv, o_sie, o_spie, o_spp, o_spv;
  logic [CAUSE_W-1:0] o_cause;
  logic [XLEN-1:0] o_pc;
  logic [1:0] o_priv, o_mpp;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  trap_return_unit #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog act=%0d exp<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [8:0] pack_in();
    return {i_mie, i_mpie, i_mpp, i_mpv, i_sie, i_spie, i_spp, i_spv};
  endfunction

  function automatic logic [8:0] pack_out();
    return {o_mie, o_mpie, o_mpp, o_mpv, o_sie, o_spie, o_spp, o_spv};
  endfunction

  logic       e_exc;
  logic [3:0] e_cause;
  logic [1:0] e_priv;
  logic       e_virt;
  logic [8:0] e_st;
  logic [31:0] e_pc;

  // expected values from the requirements
  task automatic model();
    logic mis, ill_p, ill_t;
    e_pc  = i_is_mret ? i_mepc : i_sepc;
    mis   = !i_rvc && (e_pc[1:0] != 2'b00);
    ill_p = i_is_mret ? (i_priv != 2'b11) : (i_priv == 2'b00);
    ill_t = !i_is_mret && i_tsr && (i_priv != 2'b11);
    e_exc = ill_p || mis || ill_t;
    e_cause = ill_p ? 4'd2 : (mis ? 4'd0 : (ill_t ? 4'd2 : 4'd0));
    if (e_exc) begin
      e_priv = i_priv; e_virt = i_virt; e_st = pack_in();
    end else if (i_is_mret) begin
      e_priv = i_mpp;
      e_virt = i_hyp ? i_mpv : i_virt;
      e_st   = {i_mpie, 1'b1, 2'b00, 1'b0, i_sie, i_spie, i_spp, i_spv};
    end else begin
      e_priv = i_spp ? 2'b01 : 2'b00;
      e_virt = (i_hyp && !i_virt) ? i_spv : i_virt;
      e_st   = {i_mie, i_mpie, i_mpp, i_mpv, i_spie, 1'b1, 1'b0,
                ((i_hyp && !i_virt) ? 1'b0 : i_spv)};
    end
  endtask

  initial begin
    int k;
    k = 0;
    rst_n = 1'b0;
    {i_req, i_is_mret, i_virt, i_mie, i_mpie, i_mpv, i_sie, i_spie, i_spp, i_spv} = '0;
    {i_tsr, i_rvc, i_hyp, i_priv, i_mpp} = '0;
    i_mepc = '0; i_sepc = '0;
    repeat (3) @(negedge clk);
    chk("R12 done", 64'(o_done), 64'd0);
    chk("R12 exc", 64'(o_exc), 64'd0);
    chk("R12 priv", 64'(o_priv), 64'd3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle done", 64'(o_done), 64'd0);

    for (int im = 0; im < 2; im++)
    for (int pv = 0; pv < 4; pv++)
    for (int ts = 0; ts < 2; ts++)
    for (int rv = 0; rv < 2; rv++)
    for (int hy = 0; hy < 2; hy++)
    for (int vi = 0; vi < 2; vi++)
    for (int lb = 0; lb < 4; lb++)
    for (int sp = 0; sp < 4; sp++) begin
      logic [8:0] pat;
      logic [1:0] hold_priv;
      logic [8:0] hold_st;
      pat = 9'((k * 37 + 11 + sp * 101) & 9'h1ff);
      k++;
      i_req = 1'b1;
      i_is_mret = im[0]; i_priv = pv[1:0]; i_tsr = ts[0]; i_rvc = rv[0];
      i_hyp = hy[0]; i_virt = vi[0];
      {i_mie, i_mpie, i_mpp, i_mpv, i_sie, i_spie, i_spp, i_spv} = pat;
      i_mepc = 32'h8000_0000 | (32'(k) << 4) | 32'(lb);
      i_sepc = 32'h4000_0000 | (32'(k) << 6) | 32'(3 - lb);
      model();
      @(negedge clk);
      i_req = 1'b0;
      chk("R1 done", 64'(o_done), 64'd1);
      if (!im[0] && pv == 1 && ts == 1)
        chk("R4/R5 tsr vs align", 64'(o_exc), 64'(e_exc));
      else if (im[0])
        chk("R2 mret exc", 64'(o_exc), 64'(e_exc));
      else
        chk("R3 sret exc", 64'(o_exc), 64'(e_exc));
      chk("R5 cause", 64'(o_cause), 64'(e_cause));
      chk("R6 priv", 64'(o_priv), 64'(e_priv));
      if (im[0]) begin
        chk("R8 virt", 64'(o_virt), 64'(e_virt));
        chk("R7 stack", 64'(pack_out()), 64'(e_st));
      end else begin
        chk("R10 virt", 64'(o_virt), 64'(e_virt));
        chk("R9 stack", 64'(pack_out()), 64'(e_st));
      end
      chk("R11 pc", 64'(o_pc), 64'(e_pc));
      hold_priv = o_priv;
      hold_st   = pack_out();
      // change inputs with no request: outputs must not move
      i_priv = ~i_priv; i_mpp = ~i_mpp; i_spie = ~i_spie;
      @(negedge clk);
      chk("R1 done low", 64'(o_done), 64'd0);
      chk("R1 hold priv", 64'(o_priv), 64'(hold_priv));
      chk("R1 hold stack", 64'(pack_out()), 64'(hold_st));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule